// File: doc/BRIEF.md
# Multi-Channel PWM Register Bank

This block drives sixteen pulse-width outputs from a single 12-bit cycle counter. The counter counts 0 to 4095 and steps once for each pulse on a tick input, which comes from an external rate divider. Each channel holds a 12-bit rising-edge count, a 12-bit falling-edge count and two override flags. The first flag forces the output low. The second forces it high. Forcing low has the higher priority, and the edge-count window comes last.

Software reaches the channel settings through a plain byte-wide register port. The port has an address, write data with a write strobe, and a read strobe. Read data appears one clock after the read strobe. The port has no back-pressure: a strobe is taken in the cycle in which it is high. Four addresses near the top of the map form a broadcast group. A write to one of them updates the same byte in every channel. A read from one of them returns zero.

Top module: `pwm_bank`

## Requirements
- R1: The internal cycle counter resets to 0. It advances by one on each clock where `tick` is high, wraps from 4095 to 0, and holds when `tick` is low.
- R2: After reset every channel has both edge counts at 0, the force-high flag clear and the force-low flag set. All outputs are low and `bus_rdata` is 0.
- R3: Channel n (0..15) takes four bytes starting at address 0x06+4n, in this order: rising low, rising high, falling low, falling high. A low byte holds count bits 7..0. In a high byte, bits 3..0 hold count bits 11..8, bit 4 holds the flag (force-high in the rising byte, force-low in the falling byte), and bits 7..5 read as 0. A read strobe loads the addressed byte into `bus_rdata` at the next clock edge.
- R4: While force-low is set, the channel output is low, whatever the other settings are.
- R5: While force-high is set and force-low is clear, the output is high during the whole cycle.
- R6: A write to the falling-high byte loads force-low from bit 4 of the same data byte. Writing a plain count therefore clears force-low.
- R7: When no flag is set and the rising count is at most the falling count, the output is high exactly when rising ≤ counter < falling. Equal counts give a permanently low output.
- R8: When no flag is set and the rising count is greater than the falling count, the output is high when counter ≥ rising or counter < falling, so the high window wraps through 0.
- R9: Writes to 0xFA, 0xFB, 0xFC and 0xFD update, in every channel, the rising low, rising high, falling low and falling high byte respectively.
- R10: Reads from the broadcast addresses and from unmapped addresses return 0. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advances the cycle counter by one |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the clock after `bus_re` |
| pwm_out | output | 16 | One output per channel |

## Verification
The bench targets these corner cases:
- A window that wraps past 4095. A plain magnitude compare would leave that channel dark.
- Equal edge counts. An inclusive compare would produce a one-count glitch.
- Windows ending at 4095 and starting at 4095. An off-by-one error would show at these extremes.
- Both flags set together. A wrong priority order would drive the output high.
- Re-enabling a channel with a plain count write. If force-low were left sticky, the output would stay dark.
- Broadcast addresses. A design that reads back a channel value there would return a non-zero byte.
- Gaps in `tick`. A counter that ran on every clock would move the edges.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int CNT_W    = 12;
  localparam int BYTE_W   = 8;
  localparam int HI_W     = CNT_W - BYTE_W;
  localparam int FLAG_BIT = HI_W;
  localparam int NBYTES   = 4;

  typedef enum logic [1:0] {
    B_RISE_LO = 2'd0,
    B_RISE_HI = 2'd1,
    B_FALL_LO = 2'd2,
    B_FALL_HI = 2'd3
  } byte_sel_e;
endpackage

// File: rtl/pwm_cycle_counter.sv
module pwm_cycle_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  p_tick_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == ($past(count) + 1'b1));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NBYTES-1:0]           wr_sel,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic [CNT_W-1:0]            count,
  output logic [NBYTES-1:0][BYTE_W-1:0] rd_bytes,
  output logic                        pwm
);
  logic [CNT_W-1:0] rise_cnt, fall_cnt;
  logic             force_hi, force_lo;
  logic             in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      fall_cnt <= '0;
      force_hi <= 1'b0;
      force_lo <= 1'b1;
    end else begin
      if (wr_sel[int'(B_RISE_LO)]) rise_cnt[BYTE_W-1:0] <= wdata;
      if (wr_sel[int'(B_RISE_HI)]) begin
        rise_cnt[CNT_W-1:BYTE_W] <= wdata[HI_W-1:0];
        force_hi                 <= wdata[FLAG_BIT];
      end
      if (wr_sel[int'(B_FALL_LO)]) fall_cnt[BYTE_W-1:0] <= wdata;
      if (wr_sel[int'(B_FALL_HI)]) begin
        fall_cnt[CNT_W-1:BYTE_W] <= wdata[HI_W-1:0];
        force_lo                 <= wdata[FLAG_BIT];
      end
    end
  end

  always_comb begin
    rd_bytes[int'(B_RISE_LO)] = rise_cnt[BYTE_W-1:0];
    rd_bytes[int'(B_RISE_HI)] = {{(BYTE_W-HI_W-1){1'b0}}, force_hi, rise_cnt[CNT_W-1:BYTE_W]};
    rd_bytes[int'(B_FALL_LO)] = fall_cnt[BYTE_W-1:0];
    rd_bytes[int'(B_FALL_HI)] = {{(BYTE_W-HI_W-1){1'b0}}, force_lo, fall_cnt[CNT_W-1:BYTE_W]};
  end

  // Window compare: plain when rise <= fall, wrapping through zero otherwise
  always_comb begin
    if (rise_cnt <= fall_cnt) in_win = (count >= rise_cnt) && (count < fall_cnt);
    else                      in_win = (count >= rise_cnt) || (count < fall_cnt);
  end

  // Priority: force-low, then force-high, then window
  assign pwm = force_lo ? 1'b0 : (force_hi ? 1'b1 : in_win);

  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
  p_plain_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[int'(B_FALL_HI)] && !wdata[FLAG_BIT] |=> !rd_bytes[int'(B_FALL_HI)][FLAG_BIT]);
  p_force_low_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[int'(B_FALL_HI)] && wdata[FLAG_BIT] |=> !pwm);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int          NUM_CH  = 16,
  parameter logic [7:0]  CH_BASE = 8'h06,
  parameter logic [7:0]  BC_BASE = 8'hFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int CH_SPAN = NBYTES * NUM_CH;
  localparam logic [7:0] BC_LAST = 8'(BC_BASE + 8'd3);

  logic [CNT_W-1:0] count;
  logic [7:0]       ch_off;
  logic [5:0]       ch_idx;
  logic [1:0]       ch_byte, bc_byte, wr_byte;
  logic             ch_hit, bc_hit;
  logic [NBYTES-1:0][BYTE_W-1:0] rd_bytes [NUM_CH];
  logic [7:0]       rd_mux;

  pwm_cycle_counter #(.W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count)
  );

  // Address decode
  assign ch_off  = bus_addr - CH_BASE;
  assign ch_idx  = ch_off[7:2];
  assign ch_byte = ch_off[1:0];
  assign ch_hit  = (bus_addr >= CH_BASE) && (int'(ch_off) < CH_SPAN);
  assign bc_hit  = (bus_addr >= BC_BASE) && (bus_addr <= BC_LAST);
  assign bc_byte = 2'(bus_addr - BC_BASE);
  assign wr_byte = bc_hit ? bc_byte : ch_byte;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [NBYTES-1:0] sel;
    assign sel = (bus_we && (bc_hit || (ch_hit && ch_idx == 6'(g))))
                 ? (NBYTES'(1) << wr_byte) : '0;
    pwm_channel u_ch (
      .clk(clk), .rst_n(rst_n), .wr_sel(sel), .wdata(bus_wdata),
      .count(count), .rd_bytes(rd_bytes[g]), .pwm(pwm_out[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_hit && ch_idx == 6'(i)) rd_mux = rd_bytes[i][ch_byte];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  p_bcast_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bc_hit |=> bus_rdata == 8'h00);
  p_bcast_force_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == BC_LAST && bus_wdata[FLAG_BIT] |=> pwm_out == '0);
endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] pwm_out;

  always #4 clk = ~clk;  // 125 MHz

  pwm_bank i_pwm_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // Behavioural reference state
  int        m_cnt;
  int        m_rise [16];
  int        m_fall [16];
  bit        m_fhi  [16];
  bit        m_flo  [16];
  int        m_rdata;
  int        errors = 0, checks = 0;
  string     cur_tag = "R2";
  bit        done = 1'b0;

  function automatic int mdl_read(int a);
    int n, b;
    if (a >= 6 && a < 6 + 64) begin
      n = (a - 6) / 4; b = (a - 6) % 4;
      case (b)
        0: return m_rise[n] % 256;
        1: return (m_fhi[n] ? 16 : 0) + m_rise[n] / 256;
        2: return m_fall[n] % 256;
        default: return (m_flo[n] ? 16 : 0) + m_fall[n] / 256;
      endcase
    end
    return 0;
  endfunction

  function automatic void mdl_wr_one(int n, int b, int d);
    case (b)
      0: m_rise[n] = (m_rise[n] / 256) * 256 + d;
      1: begin m_rise[n] = (d % 16) * 256 + m_rise[n] % 256; m_fhi[n] = d[4]; end
      2: m_fall[n] = (m_fall[n] / 256) * 256 + d;
      default: begin m_fall[n] = (d % 16) * 256 + m_fall[n] % 256; m_flo[n] = d[4]; end
    endcase
  endfunction

  function automatic bit mdl_pwm(int n);
    if (m_flo[n]) return 1'b0;
    if (m_fhi[n]) return 1'b1;
    if (m_rise[n] <= m_fall[n]) return (m_cnt >= m_rise[n]) && (m_cnt < m_fall[n]);
    return (m_cnt >= m_rise[n]) || (m_cnt < m_fall[n]);
  endfunction

  function automatic string pwm_tag(int n);
    if (m_flo[n]) return "R4";
    if (m_fhi[n]) return "R5";
    if (m_rise[n] <= m_fall[n]) return "R7";
    return "R8";
  endfunction

  task automatic compare_all();
    bit bad;
    checks++;
    bad = 1'b0;
    for (int n = 0; n < 16; n++) begin
      if (!bad && pwm_out[n] !== mdl_pwm(n)) begin
        bad = 1'b1;
        errors++;
        $display("FAIL R1 %s ch%0d count=%0d: actual=%0b expected=%0b",
                 pwm_tag(n), n, m_cnt, pwm_out[n], mdl_pwm(n));
      end
    end
    checks++;
    if (int'(bus_rdata) !== m_rdata) begin
      errors++;
      $display("FAIL %s rdata: actual=0x%02h expected=0x%02h", cur_tag, bus_rdata, m_rdata);
    end
  endtask

  task automatic step(input int a, input int d, input bit w, input bit r, input bit t);
    bus_addr = 8'(a); bus_wdata = 8'(d); bus_we = w; bus_re = r; tick = t;
    @(posedge clk);
    if (r) m_rdata = mdl_read(a);
    if (w) begin
      if (a >= 6 && a < 6 + 64) mdl_wr_one((a - 6) / 4, (a - 6) % 4, d);
      else if (a >= 'hFA && a <= 'hFD)
        for (int n = 0; n < 16; n++) mdl_wr_one(n, a - 'hFA, d);
    end
    if (t) m_cnt = (m_cnt + 1) % 4096;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0; tick = 1'b0;
    compare_all();
  endtask

  task automatic wr(input int a, input int d); step(a, d, 1'b1, 1'b0, 1'b0); endtask
  task automatic rd(input int a);              step(a, 0, 1'b0, 1'b1, 1'b0); endtask
  task automatic run(input int cycles, input int every);
    for (int k = 0; k < cycles; k++) step(0, 0, 1'b0, 1'b0, (k % every) == 0);
  endtask

  initial begin
    m_cnt = 0; m_rdata = 0;
    for (int n = 0; n < 16; n++) begin
      m_rise[n] = 0; m_fall[n] = 0; m_fhi[n] = 1'b0; m_flo[n] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    cur_tag = "R2"; compare_all();
    for (int a = 6; a < 10; a++) rd(a);
    rd('h45);
    // R3: layout and readback, upper bits dropped
    cur_tag = "R3";
    wr(6, 'h00); wr(7, 'hE1); wr(8, 'h00); wr(9, 'h03);       // ch0 0x100..0x300, R7
    for (int a = 6; a < 10; a++) rd(a);
    wr(10, 'h00); wr(11, 'h0F); wr(12, 'h80); wr(13, 'h00);   // ch1 wraps, R8
    wr(15, 'h10); wr(17, 'h00);                               // ch2 force-high, R5
    wr(19, 'h10);                                             // ch3 both flags, R4
    wr(23, 'h02); wr(25, 'h02);                               // ch4 equal counts, R7
    wr(28, 'hFF); wr(29, 'h0F);                               // ch5 0..4095, R7
    wr(30, 'hFF); wr(31, 'h0F); wr(32, 'h01); wr(33, 'h00);   // ch6 4095..1, R8
    for (int a = 10; a < 34; a++) rd(a);
    run(4200, 1);
    run(3000, 3);                                             // R1: tick gaps
    // R6: force-low via falling-high byte, then cleared by plain count
    cur_tag = "R6";
    wr(9, 'h13); run(40, 1); rd(9);
    wr(9, 'h03); run(300, 1); rd(9);
    // R9: broadcast writes
    cur_tag = "R9";
    wr('hFA, 'h40); wr('hFB, 'h00); wr('hFC, 'h20); wr('hFD, 'h08);
    for (int a = 'h42; a < 'h46; a++) rd(a);
    rd(6); rd(9);
    run(4200, 1);
    // R10: broadcast and unmapped reads return zero, unmapped writes ignored
    cur_tag = "R10";
    for (int a = 'hFA; a <= 'hFD; a++) rd(a);
    wr('h50, 'hFF); wr('h00, 'h55); wr('h05, 'h1F); wr('hFE, 'h10);
    rd('h50); rd('h05); rd(6); rd(9);
    run(600, 1);
    cur_tag = "R9";
    wr('hFD, 'h10); run(100, 1); rd('h2D);                    // all forced low
    wr('hFB, 'h10); wr('hFD, 'h00); run(100, 1); rd('h2B);    // all forced high
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule